// File: doc/BRIEF.md
# Dodecagonal Sector and Dwell-Time Calculator

This block turns one sampled set of three signed phase reference values into the data a multilevel space-vector modulator needs at the start of a carrier period. It finds the 60-degree hexagonal sector that holds the reference, computes the two active-vector dwell times, and reports which 30-degree half of that sector the reference lies in. It uses only sorting, subtraction and constant multiplication. It needs no lookup tables and no matrix arithmetic.

A caller presents `va`, `vb`, `vc` and the sampling period `ts`, and raises `in_valid` for one cycle. Three clock edges later `out_done` pulses and the results appear. The division by the outermost hexagon radius is a multiply by a reciprocal that is derived from the `VHEX` parameter at elaboration, followed by a right shift of `FRAC` bits. The pipeline accepts one new sample on every cycle.

Top module: `dodec_dwell_calc`

## Requirements
- R1: The sector code on `out_sector` comes from the ordering of the three samples, as follows. a>b>c gives 1, b>c>a gives 2, c>a>b gives 3, a>c>b gives 4, c>b>a gives 5 and b>a>c gives 6. The code is never 0 or 7.
- R2: When two or more samples are equal, the phase with the lower index (a before b before c) counts as the larger one. For example, a=b>c gives sector 1, b=c>a gives sector 2, and a=b=c gives sector 1 with both dwell times 0.
- R3: In odd sectors, `out_t1` is the scaled value of (max−mid) and `out_t2` is the scaled value of (mid−min).
- R4: In even sectors the two assignments of R3 are swapped: `out_t1` is the scaled value of (mid−min) and `out_t2` is the scaled value of (max−mid).
- R5: Scaling a difference d gives (ts·d·K) >> FRAC, truncated, where K = (2^FRAC + VHEX/2) / VHEX in integer division. This is ts·d/VHEX.
- R6: `out_first_half` is 1 exactly when the unsaturated T1 is strictly greater than the unsaturated T2. When they are equal it is 0.
- R7: T1 is clamped to ts, and T2 is clamped to ts minus the clamped T1. The sum `out_t1 + out_t2` therefore never exceeds ts.
- R8: `out_done` goes high on the third rising edge counting the edge that samples `in_valid`, and stays high for one cycle for each accepted sample. Between pulses the result outputs hold their values.
- R9: Samples given on consecutive cycles produce results on consecutive cycles, in the order they were given.
- R10: While reset is asserted and after it is released, `out_done` is 0, `out_sector` is 1, and `out_t1`, `out_t2` and `out_first_half` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe: the samples and the period are valid |
| va | input | W | Phase a reference, signed |
| vb | input | W | Phase b reference, signed |
| vc | input | W | Phase c reference, signed |
| ts | input | TW | Sampling period in timer ticks, unsigned |
| out_done | output | 1 | Result valid pulse |
| out_sector | output | 3 | Hexagonal sector, 1 to 6 |
| out_t1 | output | TW | First active-vector dwell time |
| out_t2 | output | TW | Second active-vector dwell time |
| out_first_half | output | 1 | Reference lies in the first 30 degrees of the sector |

## Verification
The hardest case to bring about is the partial clamp. Here the raw T1 fits within ts but the raw T2 pushes the sum past it, so only T2 is trimmed. Reaching it takes a wide phase spread combined with a deliberately short ts, with the samples placed so that (mid−min) is larger than (max−mid). A further test uses exactly equal samples to drive each tie-break arm in turn. A third test sends three samples on back-to-back cycles, so that every pipeline stage holds a different sample at the same time.

// File: rtl/dwell_pkg.sv
package dwell_pkg;
    typedef enum logic [2:0] {
        SEC_NONE = 3'd0,
        SEC_1    = 3'd1,
        SEC_2    = 3'd2,
        SEC_3    = 3'd3,
        SEC_4    = 3'd4,
        SEC_5    = 3'd5,
        SEC_6    = 3'd6
    } sector_e;
endpackage

// File: rtl/dwell_sort.sv
// Orders the three phase samples, names the sector and forms the two
// parity-swapped differences that feed the dwell-time scaling.
module dwell_sort
    import dwell_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] c,
    output sector_e             sector,
    output logic [W:0]          d1,
    output logic [W:0]          d2
);
    localparam int DW = W + 2;

    logic              a_ge_b, a_ge_c, b_ge_c;
    logic signed [DW-1:0] vmax, vmid, vmin;
    logic signed [DW-1:0] hi_diff, lo_diff;

    // ties resolve toward the lower-indexed phase
    assign a_ge_b = (a >= b);
    assign a_ge_c = (a >= c);
    assign b_ge_c = (b >= c);

    always_comb begin
        sector = SEC_1;
        vmax   = DW'(a);
        vmid   = DW'(b);
        vmin   = DW'(c);
        unique case ({a_ge_b, a_ge_c, b_ge_c})
            3'b111: begin sector = SEC_1; vmax = DW'(a); vmid = DW'(b); vmin = DW'(c); end
            3'b001: begin sector = SEC_2; vmax = DW'(b); vmid = DW'(c); vmin = DW'(a); end
            3'b100: begin sector = SEC_3; vmax = DW'(c); vmid = DW'(a); vmin = DW'(b); end
            3'b110: begin sector = SEC_4; vmax = DW'(a); vmid = DW'(c); vmin = DW'(b); end
            3'b000: begin sector = SEC_5; vmax = DW'(c); vmid = DW'(b); vmin = DW'(a); end
            3'b011: begin sector = SEC_6; vmax = DW'(b); vmid = DW'(a); vmin = DW'(c); end
            default: begin sector = SEC_1; vmax = DW'(a); vmid = DW'(b); vmin = DW'(c); end
        endcase
    end

    assign hi_diff = vmax - vmid;
    assign lo_diff = vmid - vmin;

    // odd sectors: T1 from upper gap; even sectors: swapped
    always_comb begin
        if (sector[0]) begin
            d1 = hi_diff[W:0];
            d2 = lo_diff[W:0];
        end else begin
            d1 = lo_diff[W:0];
            d2 = hi_diff[W:0];
        end
    end
endmodule

// File: rtl/dwell_scale.sv
// Multiplies a phase gap by the period and by the reciprocal of the
// hexagon radius, then drops the fractional bits.
module dwell_scale #(
    parameter int          DIFF_W = 17,
    parameter int          TW     = 16,
    parameter int          FRAC   = 24,
    parameter longint      RECIP  = 839,
    parameter int          PROD_W = 58,
    parameter int          RAW_W  = 34
) (
    input  logic [DIFF_W-1:0] diff,
    input  logic [TW-1:0]     ts,
    output logic [RAW_W-1:0]  raw
);
    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(ts) * PROD_W'(diff) * PROD_W'(RECIP);
    assign raw  = prod[PROD_W-1:FRAC];
endmodule

// File: rtl/dwell_limit.sv
// Clamps the dwell pair into the period and classifies the half-sector.
module dwell_limit #(
    parameter int TW    = 16,
    parameter int RAW_W = 34
) (
    input  logic [RAW_W-1:0] raw1,
    input  logic [RAW_W-1:0] raw2,
    input  logic [TW-1:0]    ts,
    output logic [TW-1:0]    t1,
    output logic [TW-1:0]    t2,
    output logic             first_half
);
    logic [TW-1:0] room;

    assign t1         = (raw1 > RAW_W'(ts)) ? ts : raw1[TW-1:0];
    assign room       = ts - t1;
    assign t2         = (raw2 > RAW_W'(room)) ? room : raw2[TW-1:0];
    assign first_half = (raw1 > raw2);
endmodule

// File: rtl/dodec_dwell_calc.sv
// Three-stage pipeline: sort -> scale -> clamp.
module dodec_dwell_calc
    import dwell_pkg::*;
#(
    parameter int W    = 16,
    parameter int TW   = 16,
    parameter int FRAC = 24,
    parameter int VHEX = 20000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] va,
    input  logic signed [W-1:0] vb,
    input  logic signed [W-1:0] vc,
    input  logic [TW-1:0]       ts,
    output logic                out_done,
    output logic [2:0]          out_sector,
    output logic [TW-1:0]       out_t1,
    output logic [TW-1:0]       out_t2,
    output logic                out_first_half
);
    localparam int     DIFF_W  = W + 1;
    localparam longint RECIP   = ((longint'(1) << FRAC) + VHEX / 2) / VHEX;
    localparam int     RECIP_W = FRAC + 1;
    localparam int     PROD_W  = DIFF_W + TW + RECIP_W;
    localparam int     RAW_W   = PROD_W - FRAC;
    localparam int     NCH     = 2;

    // stage 1: ordering
    sector_e           sort_sector;
    logic [DIFF_W-1:0] sort_d [NCH];

    dwell_sort #(.W(W)) u_sort (
        .a      (va),
        .b      (vb),
        .c      (vc),
        .sector (sort_sector),
        .d1     (sort_d[0]),
        .d2     (sort_d[1])
    );

    logic              s1_vld;
    sector_e           s1_sector;
    logic [DIFF_W-1:0] s1_d [NCH];
    logic [TW-1:0]     s1_ts;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            s1_sector <= SEC_1;
            s1_ts     <= '0;
            s1_d[0]   <= '0;
            s1_d[1]   <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_sector <= sort_sector;
                s1_ts     <= ts;
                s1_d[0]   <= sort_d[0];
                s1_d[1]   <= sort_d[1];
            end
        end
    end

    // stage 2: scaling, one multiplier per channel
    logic [RAW_W-1:0] scl_raw [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_scale
        dwell_scale #(
            .DIFF_W (DIFF_W),
            .TW     (TW),
            .FRAC   (FRAC),
            .RECIP  (RECIP),
            .PROD_W (PROD_W),
            .RAW_W  (RAW_W)
        ) u_scale (
            .diff (s1_d[k]),
            .ts   (s1_ts),
            .raw  (scl_raw[k])
        );
    end

    logic             s2_vld;
    sector_e          s2_sector;
    logic [RAW_W-1:0] s2_raw [NCH];
    logic [TW-1:0]    s2_ts;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld    <= 1'b0;
            s2_sector <= SEC_1;
            s2_ts     <= '0;
            s2_raw[0] <= '0;
            s2_raw[1] <= '0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_sector <= s1_sector;
                s2_ts     <= s1_ts;
                s2_raw[0] <= scl_raw[0];
                s2_raw[1] <= scl_raw[1];
            end
        end
    end

    // stage 3: clamping and result registers
    logic [TW-1:0] lim_t1, lim_t2;
    logic          lim_half;

    dwell_limit #(.TW(TW), .RAW_W(RAW_W)) u_limit (
        .raw1       (s2_raw[0]),
        .raw2       (s2_raw[1]),
        .ts         (s2_ts),
        .t1         (lim_t1),
        .t2         (lim_t2),
        .first_half (lim_half)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done       <= 1'b0;
            out_sector     <= 3'(SEC_1);
            out_t1         <= '0;
            out_t2         <= '0;
            out_first_half <= 1'b0;
        end else begin
            out_done <= s2_vld;
            if (s2_vld) begin
                out_sector     <= 3'(s2_sector);
                out_t1         <= lim_t1;
                out_t2         <= lim_t2;
                out_first_half <= lim_half;
            end
        end
    end

    // result checks, beside the registers they watch
    assert_sector_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_sector >= 3'd1 && out_sector <= 3'd6));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ((TW+1)'(out_t1) + (TW+1)'(out_t2) <= (TW+1)'($past(s2_ts))));

    assert_half_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_first_half) |-> (out_t1 > out_t2));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_done);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> ($stable(out_t1) && $stable(out_t2) && $stable(out_sector)
                       && $stable(out_first_half)));
endmodule

// File: tb/tb_dodec_dwell_calc.sv
`timescale 1ns/1ps
module tb_dodec_dwell_calc;
    localparam int     W    = 16;
    localparam int     TW   = 16;
    localparam int     FRAC = 24;
    localparam int     VHEX = 20000;
    localparam longint K    = ((longint'(1) << FRAC) + VHEX / 2) / VHEX;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] va = '0, vb = '0, vc = '0;
    logic [TW-1:0]       ts = '0;
    logic                out_done;
    logic [2:0]          out_sector;
    logic [TW-1:0]       out_t1, out_t2;
    logic                out_first_half;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dodec_dwell_calc #(.W(W), .TW(TW), .FRAC(FRAC), .VHEX(VHEX)) dut (
        .clk, .rst_n, .in_valid, .va, .vb, .vc, .ts,
        .out_done, .out_sector, .out_t1, .out_t2, .out_first_half
    );

    typedef struct {
        int     sec;
        longint t1;
        longint t2;
        int     half;
    } exp_t;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(int a, int b, int c, longint t);
        exp_t   e;
        int     mx, md, mn;
        longint gh, gl, r1, r2, c1, room;
        if (a >= b && b >= c)               begin e.sec = 1; mx = a; md = b; mn = c; end
        else if (b > a && b >= c && c > a)  begin e.sec = 2; mx = b; md = c; mn = a; end
        else if (c > a && a >= b)           begin e.sec = 3; mx = c; md = a; mn = b; end
        else if (a >= c && c > b)           begin e.sec = 4; mx = a; md = c; mn = b; end
        else if (c > b && b > a)            begin e.sec = 5; mx = c; md = b; mn = a; end
        else                                begin e.sec = 6; mx = b; md = a; mn = c; end
        gh = longint'(mx - md);
        gl = longint'(md - mn);
        if (e.sec % 2 == 1) begin
            r1 = (t * gh * K) >> FRAC;
            r2 = (t * gl * K) >> FRAC;
        end else begin
            r1 = (t * gl * K) >> FRAC;
            r2 = (t * gh * K) >> FRAC;
        end
        e.half = (r1 > r2) ? 1 : 0;
        c1     = (r1 > t) ? t : r1;
        room   = t - c1;
        e.t1   = c1;
        e.t2   = (r2 > room) ? room : r2;
        return e;
    endfunction

    task automatic check_result(string req, exp_t e);
        check(req, "done", longint'(out_done), 1);
        check(req, "sector", longint'(out_sector), longint'(e.sec));
        check(req, "t1", longint'(out_t1), e.t1);
        check(req, "t2", longint'(out_t2), e.t2);
        check(req, "first_half", longint'(out_first_half), longint'(e.half));
    endtask

    // one sample; checks the latency and the result
    task automatic run_one(string req, int a, int b, int c, int t);
        exp_t e;
        e = model(a, b, c, longint'(t));
        @(negedge clk);
        va = W'(a); vb = W'(b); vc = W'(c); ts = TW'(t); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "done after 1 edge", longint'(out_done), 0);
        @(negedge clk);
        check("R8", "done after 2 edges", longint'(out_done), 0);
        @(negedge clk);
        check_result(req, e);
    endtask

    task automatic test_reset();
        check("R10", "done", longint'(out_done), 0);
        check("R10", "sector", longint'(out_sector), 1);
        check("R10", "t1", longint'(out_t1), 0);
        check("R10", "t2", longint'(out_t2), 0);
        check("R10", "first_half", longint'(out_first_half), 0);
    endtask

    task automatic test_sectors();
        run_one("R1_R3", 9000, 2000, -11000, 40000);   // a>b>c, sector 1
        run_one("R1_R4", 3000, 9000, 5000, 40000);     // b>c>a, sector 2
        run_one("R1_R3", -2000, -7000, 9000, 40000);   // c>a>b, sector 3
        run_one("R1_R4", 8000, -9000, 1000, 40000);    // a>c>b, sector 4
        run_one("R1_R3", -8000, 500, 7500, 40000);     // c>b>a, sector 5
        run_one("R1_R4", 1000, 10000, -11000, 40000);  // b>a>c, sector 6
    endtask

    task automatic test_ties();
        run_one("R2", 5000, 5000, -10000, 30000);      // a=b>c -> 1
        run_one("R2", -6000, 3000, 3000, 30000);       // b=c>a -> 2
        run_one("R2", 4000, -2000, 4000, 30000);       // a=c>b -> 4
        run_one("R2", 1234, 1234, 1234, 30000);        // all equal -> 1, zeros
    endtask

    task automatic test_scaling();
        run_one("R5", 100, 0, -100, 65535);            // equal gaps, half 0 (R6)
        run_one("R5", 32767, -1, -32768, 777);
        run_one("R6", 15000, -14000, -15000, 50000);   // first half in sector 1
        run_one("R6", 15000, 14000, -15000, 50000);    // second half in sector 1
    endtask

    task automatic test_saturation();
        run_one("R7", 30000, 0, -30000, 1000);         // both clamp
        run_one("R7", 12000, 0, -16000, 1000);         // only T2 trimmed
        run_one("R7", 32767, 32767, -32768, 500);      // T1 zero, T2 clamps to ts
    endtask

    task automatic test_hold();
        logic [TW-1:0] h1, h2;
        logic [2:0]    hs;
        run_one("R8", 7000, -3000, 2000, 20000);
        h1 = out_t1; h2 = out_t2; hs = out_sector;
        va = 'sd100; vb = 'sd900; vc = -'sd900; ts = 16'd9;
        repeat (4) @(negedge clk);
        check("R8", "done low when idle", longint'(out_done), 0);
        check("R8", "t1 held", longint'(out_t1), longint'(h1));
        check("R8", "t2 held", longint'(out_t2), longint'(h2));
        check("R8", "sector held", longint'(out_sector), longint'(hs));
    endtask

    task automatic test_stream();
        int   sa[3] = '{9000, -5000, 200};
        int   sb[3] = '{-1000, 6000, -7000};
        int   sc[3] = '{300, 1000, 7100};
        int   st[3] = '{40000, 25000, 60000};
        exp_t e;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 3 && i < 6) begin
                e = model(sa[i-3], sb[i-3], sc[i-3], longint'(st[i-3]));
                check_result("R9", e);
            end
            if (i == 6) check("R9", "done after stream", longint'(out_done), 0);
            if (i < 3) begin
                va = W'(sa[i]); vb = W'(sb[i]); vc = W'(sc[i]); ts = TW'(st[i]);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_sectors();
        test_ties();
        test_scaling();
        test_saturation();
        test_hold();
        test_stream();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule